// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A miss arrives as an address-space identifier and a 32-bit virtual address, together with the access type. The walker looks up the page directory base for that identifier in an internal register table. It reads the directory entry through a single read port, then the table entry, and answers with a physical frame, the effective permissions, or a fault code.

Software loads the per-identifier directory bases through a small configuration write port. It first writes the identifier to a select register, then writes the base word: the directory frame number in the low bits and attribute bits above it. A control register holds a global enable bit, and walks resolve only while it is set. The walker runs one walk at a time. It accepts a new miss only when it is idle.

Top module: `ptw_walker`

## Requirements
- R1: After reset `res_valid` and `mem_req_valid` are low, `miss_ready` is high, the global enable is clear and every directory base reads as unprogrammed.
- R2: Configuration writes use `cfg_addr` 0 for control, where bit 0 is the global enable. While the enable is clear, an accepted miss is answered with fault code 3 (disabled) and no memory read is made.
- R3: A write to `cfg_addr` 1 selects identifier `cfg_wdata[6:0]`. A later write to `cfg_addr` 2 stores `cfg_wdata` as that identifier's base. A base word of zero is unprogrammed, and a miss on it gets fault code 1 (translation) with no memory read.
- R4: The first read address is the base frame (the low PA_BITS-12 bits of the base word) times 4096, plus four times virtual address bits [31:22].
- R5: The second read address is the directory entry's frame (its low PA_BITS-12 bits) times 4096, plus four times virtual address bits [21:12].
- R6: A directory entry that is zero, or that has bit 28 (next level) clear, ends the walk with fault code 1 after one read.
- R7: A table entry of zero ends the walk with fault code 1 after two reads.
- R8: On success (fault code 0), `res_pfn` is the table entry masked to its low PA_BITS-12 bits, and `res_pa` is that frame joined to virtual address bits [11:0]. Readable and writable are the AND of bit 31 and of bit 30 of both entries. Non-secure is table entry bit 29.
- R9: A read (`miss_write`=0) without the combined readable bit, or a write without the combined writable bit, gets fault code 2 (permission) after two reads.
- R10: `miss_ready` is low from the cycle after a miss is accepted until the cycle after its result, so only one walk is in flight.
- R11: A base write in the same cycle as a miss is accepted for that identifier takes effect only for later misses. The accepted walk uses the old base.
- R12: `res_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 identifier select, 2 base data |
| cfg_wdata | input | 32 | Configuration write data |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and accepting |
| miss_asid | input | 7 | Address-space identifier of the miss |
| miss_va | input | 32 | Virtual address of the miss |
| miss_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_BITS | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| res_valid | output | 1 | Walk result, one cycle |
| res_fault | output | 2 | 0 ok, 1 translation, 2 permission, 3 disabled |
| res_pfn | output | PA_BITS-12 | Physical frame number |
| res_pa | output | PA_BITS | Physical address |
| res_readable | output | 1 | Effective read permission |
| res_writable | output | 1 | Effective write permission |
| res_nonsecure | output | 1 | Non-secure attribute |

## Verification
Two functions can land in one clock edge: the configuration port writing a directory base, and the miss port accepting a walk that looks up that same base. The bench provokes this by raising the base-data write for an identifier in the same cycle as a miss on that identifier, while the old base is still zero. The accepted walk must report a translation fault with no memory read, because the old base is unprogrammed. An immediately following miss must then read from the newly written directory.

// File: rtl/ptw_pkg.sv
// ptw_pkg: shared encodings for the page table walker.
// Assumes 4 KiB pages and 32-bit table entries.
package ptw_pkg;
    localparam int ENT_W      = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 10;
    localparam int BIT_RD     = 31;
    localparam int BIT_WR     = 30;
    localparam int BIT_NS     = 29;
    localparam int BIT_NEXT   = 28;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLAT  = 2'd1,
        FLT_PERM  = 2'd2,
        FLT_OFF   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        CFG_CTRL = 2'd0,
        CFG_SEL  = 2'd1,
        CFG_BASE = 2'd2
    } cfg_reg_e;

    // A directory word that can be followed to a second-level table.
    function automatic logic dir_walkable(input logic [ENT_W-1:0] w);
        return (w != '0) && w[BIT_NEXT];
    endfunction
endpackage

// File: rtl/ptw_base_table.sv
// ptw_base_table: per-identifier directory base registers plus global enable.
// Assumes writes land at the clock edge, so a lookup in the same cycle
// sees the previous value.
module ptw_base_table
    import ptw_pkg::*;
#(
    parameter int ASID_W = 7,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [ASID_W-1:0] rd_asid,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic              rd_valid,
    output logic              enable
);
    localparam int NUM_ASID = 1 << ASID_W;

    logic [PFN_W-1:0]  pfn_q [NUM_ASID];
    logic [NUM_ASID-1:0] vld_q;
    logic [ASID_W-1:0] sel_q;
    logic              en_q;

    // Control and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == CFG_CTRL) en_q  <= cfg_wdata[0];
            if (cfg_addr == CFG_SEL)  sel_q <= cfg_wdata[ASID_W-1:0];
        end
    end

    // One base register per identifier, written through the select register.
    for (genvar g = 0; g < NUM_ASID; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pfn_q[g] <= '0;
                vld_q[g] <= 1'b0;
            end else if (cfg_wr && cfg_addr == CFG_BASE && sel_q == ASID_W'(g)) begin
                pfn_q[g] <= cfg_wdata[PFN_W-1:0];
                vld_q[g] <= (cfg_wdata != '0);
            end
        end
    end

    assign rd_pfn   = pfn_q[rd_asid];
    assign rd_valid = vld_q[rd_asid];
    assign enable   = en_q;

    // R3: a base write reaches the selected entry on the next cycle.
    a_r3_base_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == CFG_BASE) |=>
            (pfn_q[$past(sel_q)] == $past(cfg_wdata[PFN_W-1:0])));
endmodule

// File: rtl/ptw_entry_check.sv
// ptw_entry_check: combines a directory entry and a table entry into
// effective permissions, frame number and a fault verdict.
// Assumes the directory entry was already found walkable.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int PFN_W = 20
) (
    input  logic [ENT_W-1:0] dir_ent,
    input  logic [ENT_W-1:0] tbl_ent,
    input  logic             is_write,
    output logic [PFN_W-1:0] pfn,
    output logic             readable,
    output logic             writable,
    output logic             nonsecure,
    output fault_e           fault
);
    // Permission merge and fault selection.
    always_comb begin
        pfn       = tbl_ent[PFN_W-1:0];
        readable  = dir_ent[BIT_RD] & tbl_ent[BIT_RD];
        writable  = dir_ent[BIT_WR] & tbl_ent[BIT_WR];
        nonsecure = tbl_ent[BIT_NS];
        if (tbl_ent == '0)
            fault = FLT_XLAT;
        else if (is_write ? !writable : !readable)
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
// ptw_walker: sequential two-level page table walker.
// Accepts one miss at a time, reads the directory entry and then the
// table entry over a single read port, and reports one result per miss.
// Assumes the memory returns exactly one response per accepted request.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ASID_W  = 7,
    parameter int PA_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [ASID_W-1:0]  miss_asid,
    input  logic [31:0]        miss_va,
    input  logic               miss_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               res_valid,
    output logic [1:0]         res_fault,
    output logic [PA_BITS-PAGE_SHIFT-1:0] res_pfn,
    output logic [PA_BITS-1:0] res_pa,
    output logic               res_readable,
    output logic               res_writable,
    output logic               res_nonsecure
);
    localparam int PFN_W = PA_BITS - PAGE_SHIFT;

    walk_st_e         st_q;
    logic [PFN_W-1:0] base_pfn;
    logic             base_vld;
    logic             glob_en;
    logic [PFN_W-1:0] base_q;
    logic [31:0]      va_q;
    logic             wr_q;
    logic [ENT_W-1:0] dir_q;
    fault_e           fault_q;
    logic [PFN_W-1:0] pfn_q;
    logic             rd_q, wrp_q, ns_q;

    logic [PFN_W-1:0] chk_pfn;
    logic             chk_rd, chk_wr, chk_ns;
    fault_e           chk_fault;

    ptw_base_table #(.ASID_W(ASID_W), .PFN_W(PFN_W)) u_base (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_asid(miss_asid), .rd_pfn(base_pfn), .rd_valid(base_vld),
        .enable(glob_en)
    );

    ptw_entry_check #(.PFN_W(PFN_W)) u_check (
        .dir_ent(dir_q), .tbl_ent(mem_rsp_data), .is_write(wr_q),
        .pfn(chk_pfn), .readable(chk_rd), .writable(chk_wr),
        .nonsecure(chk_ns), .fault(chk_fault)
    );

    // Walk sequencing and capture of the entries and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            dir_q   <= '0;
            fault_q <= FLT_NONE;
            pfn_q   <= '0;
            rd_q    <= 1'b0;
            wrp_q   <= 1'b0;
            ns_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (miss_valid) begin
                    base_q <= base_pfn;
                    va_q   <= miss_va;
                    wr_q   <= miss_write;
                    pfn_q  <= '0;
                    rd_q   <= 1'b0;
                    wrp_q  <= 1'b0;
                    ns_q   <= 1'b0;
                    if (!glob_en) begin
                        fault_q <= FLT_OFF;
                        st_q    <= ST_RESP;
                    end else if (!base_vld) begin
                        fault_q <= FLT_XLAT;
                        st_q    <= ST_RESP;
                    end else begin
                        st_q <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: if (mem_req_ready) st_q <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rsp_valid) begin
                    dir_q <= mem_rsp_data;
                    if (dir_walkable(mem_rsp_data)) begin
                        st_q <= ST_TBL_REQ;
                    end else begin
                        fault_q <= FLT_XLAT;
                        st_q    <= ST_RESP;
                    end
                end
                ST_TBL_REQ: if (mem_req_ready) st_q <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rsp_valid) begin
                    fault_q <= chk_fault;
                    pfn_q   <= chk_pfn;
                    rd_q    <= chk_rd;
                    wrp_q   <= chk_wr;
                    ns_q    <= chk_ns;
                    st_q    <= ST_RESP;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Read address: directory slot or table slot, each a 4-byte entry in a 4 KiB page.
    always_comb begin
        if (st_q == ST_TBL_REQ)
            mem_req_addr = {dir_q[PFN_W-1:0], va_q[21:12], 2'b00};
        else
            mem_req_addr = {base_q, va_q[31:22], 2'b00};
    end

    assign miss_ready    = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
    assign res_valid     = (st_q == ST_RESP);
    assign res_fault     = fault_q;
    assign res_pfn       = pfn_q;
    assign res_pa        = {pfn_q, va_q[11:0]};
    assign res_readable  = rd_q;
    assign res_writable  = wrp_q;
    assign res_nonsecure = ns_q;

    // R12: result strobe lasts one cycle.
    a_r12_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R10: accepting a miss closes the request port.
    a_r10_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);
    // R6: a directory entry without the next-level flag stops the walk.
    a_r6_no_table_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[BIT_NEXT]) |=>
            (!mem_req_valid && res_valid && res_fault == FLT_XLAT));
    // R9: a successful write always carries write permission.
    a_r9_write_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == FLT_NONE && wr_q) |-> res_writable);
    // R2: no memory read follows a miss accepted while disabled.
    a_r2_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !glob_en) |=> (!mem_req_valid && res_fault == FLT_OFF));
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cfg_wr = 0;
    logic [1:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic        miss_valid = 0, miss_write = 0;
    logic        miss_ready;
    logic [6:0]  miss_asid = 0;
    logic [31:0] miss_va = 0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        res_valid, res_readable, res_writable, res_nonsecure;
    logic [1:0]  res_fault;
    logic [19:0] res_pfn;
    logic [31:0] res_pa;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_asid(miss_asid), .miss_va(miss_va), .miss_write(miss_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_pfn(res_pfn), .res_pa(res_pa), .res_readable(res_readable),
        .res_writable(res_writable), .res_nonsecure(res_nonsecure)
    );

    // Memory model: one-cycle read latency, absent words read as zero.
    logic [31:0] mem [logic [31:0]];
    int          nreq;
    logic [31:0] req_log [4];
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid;
        mem_rsp_data  <= (mem_req_valid && mem.exists(mem_req_addr)) ? mem[mem_req_addr] : 32'h0;
        if (mem_req_valid) begin
            if (nreq < 4) req_log[nreq] <= mem_req_addr;
            nreq <= nreq + 1;
        end
    end

    int checks = 0, errors = 0;
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    logic [1:0]  o_fault;
    logic [19:0] o_pfn;
    logic [31:0] o_pa;
    logic [2:0]  o_perm;
    int          o_reads;

    // Issue one miss, optionally with a same-cycle base write, and collect its result.
    task automatic walk(input logic [6:0] asid, input logic [31:0] va, input bit wr,
                        input bit with_cfg, input logic [31:0] cdata);
        int n;
        @(negedge clk);
        nreq = 0;
        miss_valid = 1; miss_asid = asid; miss_va = va; miss_write = wr;
        if (with_cfg) begin cfg_wr = 1; cfg_addr = 2'd2; cfg_wdata = cdata; end
        @(negedge clk);
        miss_valid = 0; cfg_wr = 0;
        n = 0;
        while (!res_valid && n < 50) begin
            check(!miss_ready, "R10 ready low during walk", {31'b0, miss_ready}, 32'h0);
            @(negedge clk); n++;
        end
        check(res_valid, "R10 result arrives", {31'b0, res_valid}, 32'h1);
        check(!miss_ready, "R10 ready low at result", {31'b0, miss_ready}, 32'h0);
        o_fault = res_fault; o_pfn = res_pfn; o_pa = res_pa;
        o_perm = {res_readable, res_writable, res_nonsecure}; o_reads = nreq;
        @(negedge clk);
        check(!res_valid, "R12 single-cycle result", {31'b0, res_valid}, 32'h0);
        check(miss_ready, "R10 ready after result", {31'b0, miss_ready}, 32'h1);
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [1:0]  fault;
        logic [1:0]  reads;
        logic [19:0] pfn;
        logic [2:0]  perm;   // readable, writable, nonsecure
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_3ABC, 1'b0, 2'd0, 2'd2, 20'h55123, 3'b110}, // R4 R5 R8 read ok
        '{32'h0040_3004, 1'b1, 2'd0, 2'd2, 20'h55123, 3'b110}, // R8 write ok
        '{32'h0040_4010, 1'b0, 2'd0, 2'd2, 20'h00777, 3'b101}, // R8 ns set
        '{32'h0040_4010, 1'b1, 2'd2, 2'd2, 20'h0,     3'b000}, // R9 no write perm
        '{32'h0080_0000, 1'b0, 2'd1, 2'd1, 20'h0,     3'b000}, // R6 zero directory entry
        '{32'h00C0_0000, 1'b0, 2'd1, 2'd1, 20'h0,     3'b000}, // R6 next flag clear
        '{32'h0040_5000, 1'b0, 2'd1, 2'd2, 20'h0,     3'b000}, // R7 zero table entry
        '{32'h0100_1FFF, 1'b0, 2'd2, 2'd2, 20'h0,     3'b000}, // R9 directory unreadable
        '{32'h0100_1FFF, 1'b1, 2'd0, 2'd2, 20'h00ABC, 3'b011}, // R8 write through
        '{32'hFFFF_F123, 1'b0, 2'd0, 2'd2, 20'h00001, 3'b100}, // R4 R5 top indices
        '{32'hFFFF_F123, 1'b1, 2'd2, 2'd2, 20'h0,     3'b000}  // R9 read-only page
    };

    function automatic logic [31:0] dir_addr(input logic [31:0] va);
        return 32'h0001_0000 + {20'b0, va[31:22], 2'b00};
    endfunction

    initial begin
        mem[32'h0001_0004] = 32'hF000_0020;
        mem[32'h0002_000C] = 32'hC9A5_5123;
        mem[32'h0002_0010] = 32'hA000_0777;
        mem[32'h0001_0008] = 32'h0000_0000;
        mem[32'h0001_000C] = 32'hE000_0030;
        mem[32'h0001_0010] = 32'h7000_0040;
        mem[32'h0004_0004] = 32'hE000_0ABC;
        mem[32'h0001_0FFC] = 32'hF000_0050;
        mem[32'h0005_0FFC] = 32'h8000_0001;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset.
        check(miss_ready, "R1 ready after reset", {31'b0, miss_ready}, 32'h1);
        check(!res_valid && !mem_req_valid, "R1 no activity after reset",
              {30'b0, res_valid, mem_req_valid}, 32'h0);

        // R2: miss while disabled, even with a base programmed.
        cfg(2'd1, 32'h5);
        cfg(2'd2, 32'h0000_0010);
        walk(7'd5, 32'h0040_3000, 1'b0, 1'b0, 32'h0);
        check(o_fault == 2'd3, "R2 disabled fault", {30'b0, o_fault}, 32'h3);
        check(o_reads == 0, "R2 no read when disabled", o_reads, 32'h0);

        cfg(2'd0, 32'h1);
        // R3: unprogrammed identifier.
        walk(7'd9, 32'h0040_3000, 1'b0, 1'b0, 32'h0);
        check(o_fault == 2'd1, "R3 unprogrammed base fault", {30'b0, o_fault}, 32'h1);
        check(o_reads == 0, "R3 no read on unprogrammed base", o_reads, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] d, t;
            v = VECS[i];
            walk(7'd5, v.va, v.wr, 1'b0, 32'h0);
            check(o_fault == v.fault, $sformatf("R6 R7 R9 fault vec%0d", i), {30'b0, o_fault}, {30'b0, v.fault});
            check(o_reads == int'(v.reads), $sformatf("R6 R7 read count vec%0d", i), o_reads, {30'b0, v.reads});
            d = dir_addr(v.va);
            check(req_log[0] == d, $sformatf("R4 directory address vec%0d", i), req_log[0], d);
            if (v.reads == 2) begin
                t = {mem[d][19:0], v.va[21:12], 2'b00};
                check(req_log[1] == t, $sformatf("R5 table address vec%0d", i), req_log[1], t);
            end
            if (v.fault == 2'd0) begin
                check(o_pfn == v.pfn, $sformatf("R8 frame vec%0d", i), {12'b0, o_pfn}, {12'b0, v.pfn});
                check(o_pa == {v.pfn, v.va[11:0]}, $sformatf("R8 physical address vec%0d", i), o_pa, {v.pfn, v.va[11:0]});
                check(o_perm == v.perm, $sformatf("R8 permissions vec%0d", i), {29'b0, o_perm}, {29'b0, v.perm});
            end
        end

        // R11: base write for identifier 6 in the cycle its miss is accepted.
        cfg(2'd1, 32'h6);
        walk(7'd6, 32'h0040_3000, 1'b0, 1'b1, 32'h0000_0010);
        check(o_fault == 2'd1, "R11 walk uses old base", {30'b0, o_fault}, 32'h1);
        check(o_reads == 0, "R11 no read with old base", o_reads, 32'h0);
        walk(7'd6, 32'h0040_3000, 1'b0, 1'b0, 32'h0);
        check(o_fault == 2'd0, "R11 next walk uses new base", {30'b0, o_fault}, 32'h0);
        check(req_log[0] == 32'h0001_0004, "R11 new base address", req_log[0], 32'h0001_0004);

        // R3: rewriting a base to zero makes it unprogrammed again.
        cfg(2'd2, 32'h0);
        walk(7'd6, 32'h0040_3000, 1'b0, 1'b0, 32'h0);
        check(o_fault == 2'd1 && o_reads == 0, "R3 cleared base", {30'b0, o_fault}, 32'h1);

        // R2: clearing the enable stops translation.
        cfg(2'd0, 32'h0);
        walk(7'd5, 32'h0040_3000, 1'b0, 1'b0, 32'h0);
        check(o_fault == 2'd3, "R2 disabled again", {30'b0, o_fault}, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule